// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Unit

This unit turns the level changes of one eight-pin GPIO port into interrupt events. Every pin has its own polarity selection, rising or falling, and the unit detects that single polarity by comparing each synchronized pin sample with the sample from the cycle before. A detected edge sets a sticky event bit. Software clears an event bit by writing a one to it. A per-pin enable mask decides which events reach the single interrupt line of the port, and that line comes from a register.

A force register is there for test. While a force bit is 1, the event bit of that pin is set on every cycle. Writing zero to the force register ends the injection. The hardware cannot detect both edges of a pin at once. To get that behaviour, software flips the polarity bit after each event, and the detector ignores the flip, so the flip itself never produces an event.

The block sits behind a plain register port: a write strobe, a byte address, write data, and read data that is combinational from the address. The pin inputs must already be synchronized to `clk`.

Top module: `gei_port_irq`

## Requirements
- R1: After reset, the event, enable, force and polarity registers all read 0 and `irq_o` is low.
- R2: Polarity bit 1 makes its pin detect a rising edge (previous sample 0, current sample 1). Polarity bit 0 makes it detect a falling edge. An edge of the other direction leaves the event bit unchanged.
- R3: An event bit stays set until a register write to address 0x14 carries a 1 in that bit position. Write bits that are 0, and write-data bits above bit 7, have no effect.
- R4: If a set cause (an edge or a force bit) and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: `irq_o` equals the OR over all pins of (event AND enable), delayed by one register stage. A pin whose enable bit is 0 never raises it.
- R6: While a force bit (address 0x1C) is 1, that pin's event bit is set every cycle and cannot be cleared. After the force register is written to 0, a clear removes the event.
- R7: Writing the polarity register (address 0x20) while the pins hold steady sets no event bit.
- R8: The first clock after reset does not compare against the reset value of the previous-sample register, so a pin held low through reset creates no falling-edge event.
- R9: The registers decode as event 0x14, enable 0x18, force 0x1C, polarity 0x20, with pin n in bit n. Any other address reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | PINS | Synchronized pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq_o | output | 1 | Port interrupt request |

## Verification
The bench holds all pins low through reset and then checks for events in the first cycle after reset. A detector that trusted the previous-sample register from the first cycle would record false falling edges on every pin.

It writes a clear and presents a new edge on the same pin in the same cycle. A design that let the clear win would lose that event.

It rewrites the polarity register several times while the pins stay still. A detector that reacted to the configuration, or that compared the pin level against the polarity bit, would record events with no edge.

It also tries to clear an event while its force bit is still set, and it changes the enable mask under a pending event. These catch a clear that overrides an active force, and an interrupt output that is combinational or one cycle late.

// File: rtl/gei_pkg.sv
package gei_pkg;

    localparam int ADDR_W = 6;

    // Register byte addresses within the port window
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_FORCE  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_EDGE   = 6'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EVENT,
        SEL_ENABLE,
        SEL_FORCE,
        SEL_EDGE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_EVENT:  s = SEL_EVENT;
            OFS_ENABLE: s = SEL_ENABLE;
            OFS_FORCE:  s = SEL_FORCE;
            OFS_EDGE:   s = SEL_EDGE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gei_regfile.sv
module gei_regfile
    import gei_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [PINS-1:0]   event_q,
    output logic [PINS-1:0]   enable_q,
    output logic [PINS-1:0]   force_q,
    output logic [PINS-1:0]   rise_sel_q,
    output logic [PINS-1:0]   clr_mask,
    output logic [DATA_W-1:0] bus_rdata
);

    typedef struct packed {
        logic [PINS-1:0] en;
        logic [PINS-1:0] frc;
        logic [PINS-1:0] rise;
    } cfg_t;

    cfg_t     st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        st_d      = st_q;
        sel       = decode_addr(bus_addr);
        clr_mask  = '0;
        bus_rdata = '0;
        if (bus_we) begin
            case (sel)
                SEL_EVENT:  clr_mask    = bus_wdata[PINS-1:0];
                SEL_ENABLE: st_d.en     = bus_wdata[PINS-1:0];
                SEL_FORCE:  st_d.frc    = bus_wdata[PINS-1:0];
                SEL_EDGE:   st_d.rise   = bus_wdata[PINS-1:0];
                default:    ;
            endcase
        end
        case (sel)
            SEL_EVENT:  bus_rdata[PINS-1:0] = event_q;
            SEL_ENABLE: bus_rdata[PINS-1:0] = st_q.en;
            SEL_FORCE:  bus_rdata[PINS-1:0] = st_q.frc;
            SEL_EDGE:   bus_rdata[PINS-1:0] = st_q.rise;
            default:    bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_q   = st_q.en;
    assign force_q    = st_q.frc;
    assign rise_sel_q = st_q.rise;

endmodule

// File: rtl/gei_edge_detect.sv
module gei_edge_detect #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_lvl,
    input  logic [PINS-1:0] rise_sel,
    output logic [PINS-1:0] hit
);

    typedef struct packed {
        logic [PINS-1:0] prev;
        logic            armed;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = pin_lvl;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev  <= '1;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // One comparator per pin; polarity chooses which transition counts
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic up, down;
        assign up     = pin_lvl[i] & ~st_q.prev[i];
        assign down   = ~pin_lvl[i] & st_q.prev[i];
        assign hit[i] = st_q.armed & (rise_sel[i] ? up : down);
    end

endmodule

// File: rtl/gei_event_bank.sv
module gei_event_bank #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] hit,
    input  logic [PINS-1:0] force_q,
    input  logic [PINS-1:0] clr_mask,
    input  logic [PINS-1:0] enable_q,
    output logic [PINS-1:0] event_q,
    output logic            irq_o
);

    typedef struct packed {
        logic [PINS-1:0] evt;
        logic            irq;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // clear first, then set causes so a coincident set survives
        st_d.evt = (st_q.evt & ~clr_mask) | hit | force_q;
        st_d.irq = |(st_q.evt & enable_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign event_q = st_q.evt;
    assign irq_o   = st_q.irq;

endmodule

// File: rtl/gei_port_irq.sv
module gei_port_irq
    import gei_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_lvl,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    logic [PINS-1:0] event_q;
    logic [PINS-1:0] enable_q;
    logic [PINS-1:0] force_q;
    logic [PINS-1:0] rise_sel_q;
    logic [PINS-1:0] clr_mask;
    logic [PINS-1:0] hit;

    gei_regfile #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .event_q    (event_q),
        .enable_q   (enable_q),
        .force_q    (force_q),
        .rise_sel_q (rise_sel_q),
        .clr_mask   (clr_mask),
        .bus_rdata  (bus_rdata)
    );

    gei_edge_detect #(.PINS(PINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .rise_sel (rise_sel_q),
        .hit      (hit)
    );

    gei_event_bank #(.PINS(PINS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .force_q  (force_q),
        .clr_mask (clr_mask),
        .enable_q (enable_q),
        .event_q  (event_q),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/gei_checker.sv
module gei_checker
    import gei_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PINS-1:0]   pin_lvl,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [PINS-1:0]   event_q,
    input logic [PINS-1:0]   enable_q,
    input logic [PINS-1:0]   force_q,
    input logic              irq_o
);

    logic first_q;
    logic evt_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end

    assign evt_wr = bus_we && (bus_addr == OFS_EVENT);

    AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |=> (event_q == '0)); // R8

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_q & enable_q) != '0) |=> irq_o); // R5

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_q & enable_q) == '0) |=> !irq_o); // R5

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_wr |=> ((event_q & $past(event_q)) == $past(event_q))); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && ((bus_wdata[PINS-1:0] & force_q) != '0))
        |=> ((event_q & $past(bus_wdata[PINS-1:0] & force_q))
             == $past(bus_wdata[PINS-1:0] & force_q))); // R4

    AST_NO_EDGE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_q && $stable(pin_lvl) && (force_q == '0))
        |=> ((event_q & ~$past(event_q)) == '0)); // R7

endmodule

bind gei_port_irq gei_checker #(.PINS(PINS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .event_q   (event_q),
    .enable_q  (enable_q),
    .force_q   (force_q),
    .irq_o     (irq_o)
);

// File: tb/sim_gei_port_irq.sv
module sim_gei_port_irq;

    localparam logic [5:0] A_EVT = 6'h14;
    localparam logic [5:0] A_EN  = 6'h18;
    localparam logic [5:0] A_FRC = 6'h1C;
    localparam logic [5:0] A_EDG = 6'h20;
    localparam logic [5:0] A_BAD = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = 8'h00;
    logic        we = 1'b0;
    logic [5:0]  addr = 6'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gei_port_irq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        pin = 8'h00;
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        rd(A_EVT, v); chk("R8 no event from reset value", v, 32'h0);
        rd(A_EN,  v); chk("R1 enable reset", v, 32'h0);
        rd(A_FRC, v); chk("R1 force reset", v, 32'h0);
        rd(A_EDG, v); chk("R1 polarity reset", v, 32'h0);
        chk("R1 irq reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        wr(A_EDG, 32'h02);
        @(negedge clk); pin = 8'h03;
        cyc(1);
        rd(A_EVT, v); chk("R2 rising on pin1 only", v, 32'h02);
        wr(A_EVT, 32'hFF);
        @(negedge clk); pin = 8'h00;
        cyc(1);
        rd(A_EVT, v); chk("R2 falling on pin0 only", v, 32'h01);
        wr(A_EVT, 32'hFF);
        rd(A_EVT, v); chk("R3 clear all", v, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        wr(A_FRC, 32'h3C);
        wr(A_FRC, 32'h00);
        rd(A_EVT, v); chk("R6 force sets events", v, 32'h3C);
        wr(A_EVT, 32'h00);
        rd(A_EVT, v); chk("R3 zero write keeps events", v, 32'h3C);
        wr(A_EVT, 32'hFFFFFF04);
        rd(A_EVT, v); chk("R3 clear bit2 only", v, 32'h38);
        wr(A_EVT, 32'h30);
        rd(A_EVT, v); chk("R3 clear bits 4 5", v, 32'h08);
    endtask

    task automatic t_irq();
        // event bit3 pending from t_sticky
        cyc(2);
        chk("R5 masked irq low", {31'h0, irq}, 32'h0);
        wr(A_EN, 32'h08);
        cyc(1);
        chk("R5 enabled irq high", {31'h0, irq}, 32'h1);
        wr(A_EN, 32'h10);
        chk("R5 irq registered one stage", {31'h0, irq}, 32'h1);
        cyc(1);
        chk("R5 irq drops after mask", {31'h0, irq}, 32'h0);
        wr(A_EN, 32'h08);
        cyc(1);
        wr(A_EVT, 32'h08);
        cyc(1);
        chk("R5 irq drops after clear", {31'h0, irq}, 32'h0);
        wr(A_EN, 32'h00);
    endtask

    task automatic t_force_clear();
        logic [31:0] v;
        wr(A_FRC, 32'h80);
        cyc(1);
        wr(A_EVT, 32'h80);
        rd(A_EVT, v); chk("R4 force beats clear", v, 32'h80);
        wr(A_FRC, 32'h00);
        rd(A_FRC, v); chk("R6 force off", v, 32'h0);
        wr(A_EVT, 32'h80);
        rd(A_EVT, v); chk("R6 clear after force off", v, 32'h0);
    endtask

    task automatic t_edge_vs_clear();
        logic [31:0] v;
        // polarity: pin1 rising, pins idle low
        @(negedge clk);
        pin = 8'h02; we = 1'b1; addr = A_EVT; wdata = 32'h02;
        @(negedge clk);
        we = 1'b0;
        rd(A_EVT, v); chk("R4 edge beats clear", v, 32'h02);
        wr(A_EVT, 32'hFF);
        @(negedge clk); pin = 8'h00;
        cyc(1);
        rd(A_EVT, v); chk("R2 falling ignored on rising pin", v, 32'h0);
    endtask

    task automatic t_cfg_change();
        logic [31:0] v;
        @(negedge clk); pin = 8'h0F;
        cyc(1);
        wr(A_EVT, 32'hFF);
        wr(A_EDG, 32'hFF);
        wr(A_EDG, 32'h00);
        wr(A_EDG, 32'hF0);
        cyc(1);
        rd(A_EVT, v); chk("R7 polarity writes create no event", v, 32'h0);
        // both-edge emulation on pin0 by flipping polarity
        wr(A_EDG, 32'h00);
        @(negedge clk); pin = 8'h0E;
        cyc(1);
        rd(A_EVT, v); chk("R2 emulated edge: fall", v, 32'h01);
        wr(A_EVT, 32'h01);
        wr(A_EDG, 32'h01);
        @(negedge clk); pin = 8'h0F;
        cyc(1);
        rd(A_EVT, v); chk("R2 emulated edge: rise", v, 32'h01);
        wr(A_EVT, 32'hFF);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_EN, 32'hA5);
        rd(A_EN, v); chk("R9 enable readback", v, 32'hA5);
        wr(A_BAD, 32'hFF);
        rd(A_BAD, v); chk("R9 unmapped reads zero", v, 32'h0);
        rd(A_EN, v); chk("R9 unmapped write ignored", v, 32'hA5);
        rd(A_FRC, v); chk("R9 force untouched", v, 32'h0);
        rd(A_EDG, v); chk("R9 polarity readback", v, 32'h01);
        wr(A_EN, 32'h00);
    endtask

    initial begin
        t_reset();
        t_polarity();
        t_sticky();
        t_irq();
        t_force_clear();
        t_edge_vs_clear();
        t_cfg_change();
        t_map();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule